// File: doc/BRIEF.md
# Processor-to-ISA I/O Address Bridge

This block sits between a big-endian processor bus and a little-endian ISA I/O bus. Processor accesses that land in an 8 MB I/O window starting at physical address 0x80000000 become ISA port requests. The window offset is turned into a 16-bit port number by one of two mappings. The map-type input chooses the mapping for each access. In the contiguous mapping the low 16 offset bits are used directly. In the discontiguous mapping the page bits of the offset are folded down next to the five lowest bits.

Data wider than a byte is byte-reversed in both directions, so the processor's byte order matches the ISA bus. A second, 4-byte decoded location serves interrupt acknowledge. A read at its first byte pulses a strobe toward an external interrupt controller and returns the vector that the controller supplies. Accesses that hit neither region go nowhere and complete with zero data.

Every request is a one-cycle pulse. The ISA side sees the translated request in the next cycle, and the response completes one cycle after that.

Top module: `isa_io_bridge`

## Requirements
- R1: A request whose address lies in [0x80000000, 0x80800000) produces port_req high for exactly the cycle after the request, with port_we and port_size copied from the request. No other address produces port_req.
- R2: With map_discontig low when the request is made, port_addr equals window offset bits [15:0].
- R3: With map_discontig high when the request is made, port_addr[4:0] equals offset[4:0] and port_addr[15:5] equals offset[22:12]. Offset bits [11:5] are dropped.
- R4: map_discontig is sampled in the request cycle. Changing it afterwards does not alter the port address of an access already issued.
- R5: cpu_size encodes 0 = byte, 1 = 16-bit and 2 or 3 = 32-bit. Write data reaches port_wdata as follows: a byte access gives {24'b0, wdata[7:0]}; a 16-bit access gives {16'b0, wdata[7:0], wdata[15:8]}; a 32-bit access gives all four bytes reversed. port_wdata is zero on reads.
- R6: An I/O-window read returns port_rdata, sampled in the port_req cycle, with the same per-size lane mapping as R5, on cpu_rdata while cpu_done is high.
- R7: A read of 0xBFFFFFF0 pulses iack_strobe for the cycle after the request. It returns the vector (sampled in that cycle) zero-extended to 32 bits and then lane-mapped as in R5.
- R8: A read of 0xBFFFFFF1 to 0xBFFFFFF3 returns zero and raises neither iack_strobe nor port_req.
- R9: A write to any of 0xBFFFFFF0 to 0xBFFFFFF3 is discarded. It raises neither iack_strobe nor port_req and completes with zero data.
- R10: An access outside both regions raises neither port_req nor iack_strobe and completes with cpu_rdata zero.
- R11: While rst_n is low, and on the first cycle after reset, port_req, iack_strobe and cpu_done are low, and cpu_rdata and port_addr are zero.
- R12: cpu_done goes high for one cycle exactly two cycles after each request, for reads and writes alike. cpu_rdata is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Physical byte address |
| cpu_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| cpu_wdata | input | 32 | Processor write data (big-endian lanes) |
| map_discontig | input | 1 | Selects the discontiguous port mapping |
| cpu_done | output | 1 | Access completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| port_req | output | 1 | ISA port access pulse |
| port_we | output | 1 | ISA write |
| port_addr | output | 16 | ISA port number |
| port_size | output | 2 | Access size forwarded to ISA |
| port_wdata | output | 32 | Lane-mapped write data |
| port_rdata | input | 32 | ISA read data, valid while port_req is high |
| irq_vec | input | 8 | Vector from the interrupt controller |
| iack_strobe | output | 1 | Interrupt acknowledge pulse |

## Verification
The bench sets one bit at a time across all 23 offset bits, in both mappings. A design that kept bits [11:5] in discontiguous mode, or shifted the page field by the wrong amount, would give a port number with the bit misplaced. Each case runs at every access size in both directions, so a swap tied to the wrong size, or applied in only one direction, shows up as reversed or stale lanes. The window edges and the four interrupt-acknowledge bytes are hit directly. A decoder off by one would forward 0x807FFFFF wrongly or miss it, and an acknowledge decode that ignored the low bits would strobe the controller on a misaligned read. The mapping input is flipped right after each request is issued, which catches a design that decodes from the live input instead of the request-time value.

// File: rtl/isa_io_bridge_pkg.sv
// Shared types for the processor-to-ISA I/O bridge.
// Assumes byte-addressed processor accesses of 1, 2 or 4 bytes.
package isa_io_bridge_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_PORT  = 2'd1,
        RG_VEC   = 2'd2,
        RG_QUIET = 2'd3
    } region_e;

endpackage

// File: rtl/isa_region_decode.sv
// Classifies a processor address: I/O window hit, acknowledge read at
// offset zero, other acknowledge access (returns zero), or miss.
// Assumes IO_BASE is aligned to the window size.
module isa_region_decode #(
    parameter int ADDR_W = 32,
    parameter int WIN_LOG2 = 23,
    parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input  logic [ADDR_W-1:0]                  addr,
    input  logic                               we,
    output isa_io_bridge_pkg::region_e         region,
    output logic [WIN_LOG2-1:0]                offset
);
    import isa_io_bridge_pkg::*;

    localparam int ACK_LOG2 = 2;

    logic in_win;
    logic in_ack;

    // Compare the upper address bits against both region tags.
    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_LOG2] == IO_BASE[ADDR_W-1:WIN_LOG2]);
        in_ack = (addr[ADDR_W-1:ACK_LOG2] == ACK_ADDR[ADDR_W-1:ACK_LOG2]);
        offset = addr[WIN_LOG2-1:0];
    end

    // Pick the region class; acknowledge writes are silent.
    always_comb begin
        if (in_win)
            region = RG_PORT;
        else if (in_ack && !we && (addr[ACK_LOG2-1:0] == '0))
            region = RG_VEC;
        else if (in_ack)
            region = RG_QUIET;
        else
            region = RG_NONE;
    end

endmodule

// File: rtl/isa_port_map.sv
// Turns a window offset into an ISA port number in one of two layouts.
// Assumes the page field plus the kept low field exactly fill PORT_W.
module isa_port_map #(
    parameter int WIN_LOG2 = 23,
    parameter int PORT_W = 16,
    parameter int PAGE_LSB = 12,
    parameter int KEEP_W = 5
) (
    input  logic [WIN_LOG2-1:0] offset,
    input  logic                discontig,
    output logic [PORT_W-1:0]   port
);
    localparam int PAGE_W = WIN_LOG2 - PAGE_LSB;

    // Select the flat or the folded layout.
    always_comb begin
        if (discontig)
            port = {offset[WIN_LOG2-1:PAGE_LSB], offset[KEEP_W-1:0]};
        else
            port = offset[PORT_W-1:0];
    end

    initial begin
        if (PAGE_W + KEEP_W != PORT_W)
            $error("isa_port_map: page and kept fields must fill the port");
    end

endmodule

// File: rtl/isa_lane_swap.sv
// Maps byte lanes between big- and little-endian order by access size.
// Bytes pass through, halves swap the low two lanes, and words reverse
// all lanes. Lanes above the access size are cleared.
module isa_lane_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]               din,
    input  isa_io_bridge_pkg::acc_size_e    size,
    output logic [DATA_W-1:0]               dout
);
    import isa_io_bridge_pkg::*;

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] rev_all;

    // Full reversal of every lane.
    for (genvar g = 0; g < LANES; g++) begin : g_rev
        assign rev_all[g*8 +: 8] = din[(LANES-1-g)*8 +: 8];
    end

    // Choose the lane mapping for the access size.
    always_comb begin
        dout = '0;
        unique case (size)
            SZ_BYTE: dout[7:0]  = din[7:0];
            SZ_HALF: dout[15:0] = {din[7:0], din[15:8]};
            default: dout       = rev_all;
        endcase
    end

endmodule

// File: rtl/isa_io_bridge.sv
// Processor-to-ISA I/O bridge. Stage 1 registers the decoded ISA request
// or acknowledge strobe; stage 2 registers completion and read data.
// Assumes cpu_req is a one-cycle pulse and port_rdata/irq_vec are valid
// in the cycle port_req/iack_strobe is high.
module isa_io_bridge #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 16,
    parameter int VEC_W = 8,
    parameter int WIN_LOG2 = 23,
    parameter int PAGE_LSB = 12,
    parameter int KEEP_W = 5,
    parameter logic [ADDR_W-1:0] IO_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              map_discontig,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              port_req,
    output logic              port_we,
    output logic [PORT_W-1:0] port_addr,
    output logic [1:0]        port_size,
    output logic [DATA_W-1:0] port_wdata,
    input  logic [DATA_W-1:0] port_rdata,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              iack_strobe
);
    import isa_io_bridge_pkg::*;

    region_e             dec_region;
    logic [WIN_LOG2-1:0] dec_offset;
    logic [PORT_W-1:0]   map_port;
    logic [DATA_W-1:0]   wr_swapped;
    logic [DATA_W-1:0]   rd_src;
    logic [DATA_W-1:0]   rd_swapped;
    acc_size_e           req_size;
    acc_size_e           s1_size;
    logic                s1_valid;

    assign req_size = acc_size_e'(cpu_size);

    isa_region_decode #(
        .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2),
        .IO_BASE(IO_BASE), .ACK_ADDR(ACK_ADDR)
    ) u_decode (
        .addr(cpu_addr), .we(cpu_we),
        .region(dec_region), .offset(dec_offset)
    );

    isa_port_map #(
        .WIN_LOG2(WIN_LOG2), .PORT_W(PORT_W),
        .PAGE_LSB(PAGE_LSB), .KEEP_W(KEEP_W)
    ) u_map (
        .offset(dec_offset), .discontig(map_discontig), .port(map_port)
    );

    isa_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
        .din(cpu_wdata), .size(req_size), .dout(wr_swapped)
    );

    // Stage 1: register the outgoing port request or acknowledge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_size     <= SZ_BYTE;
            port_req    <= 1'b0;
            port_we     <= 1'b0;
            port_addr   <= '0;
            port_size   <= '0;
            port_wdata  <= '0;
            iack_strobe <= 1'b0;
        end else begin
            s1_valid    <= cpu_req;
            s1_size     <= req_size;
            port_req    <= cpu_req && (dec_region == RG_PORT);
            iack_strobe <= cpu_req && (dec_region == RG_VEC);
            if (cpu_req) begin
                port_we    <= cpu_we;
                port_addr  <= (dec_region == RG_PORT) ? map_port : '0;
                port_size  <= cpu_size;
                port_wdata <= (cpu_we && dec_region == RG_PORT) ? wr_swapped : '0;
            end
        end
    end

    // Pick the stage-2 read source: ISA data, vector, or nothing.
    always_comb begin
        rd_src = '0;
        if (port_req && !port_we)
            rd_src = port_rdata;
        else if (iack_strobe)
            rd_src = DATA_W'(irq_vec);
    end

    isa_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
        .din(rd_src), .size(s1_size), .dout(rd_swapped)
    );

    // Stage 2: register completion and the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_done  <= s1_valid;
            cpu_rdata <= s1_valid ? rd_swapped : '0;
        end
    end

endmodule

// File: rtl/isa_io_bridge_chk.sv
// Protocol checker for isa_io_bridge, attached by bind.
module isa_io_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_done,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              port_req,
    input logic              iack_strobe
);
    // R12
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> ##2 cpu_done);
    // R1
    port_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_req |-> $past(cpu_req));
    // R7
    iack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack_strobe |-> !port_req);
    // R7
    iack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack_strobe |=> cpu_done);
    // R12
    write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && $past(cpu_we, 2) && $past(cpu_req, 2)) |-> (cpu_rdata == '0));
endmodule

bind isa_io_bridge isa_io_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .port_req(port_req),
    .iack_strobe(iack_strobe)
);

// File: tb/isa_io_bridge_bench.sv
// Sweeps offsets, sizes, directions and both mappings; expected values
// are computed from the requirements.
module isa_io_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        map_discontig = 1'b0;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        port_req;
    logic        port_we;
    logic [15:0] port_addr;
    logic [1:0]  port_size;
    logic [31:0] port_wdata;
    logic [31:0] port_rdata;
    logic [7:0]  irq_vec = 8'h5A;
    logic        iack_strobe;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    // Simple device model: data depends on the port number.
    assign port_rdata = port_req ? {~port_addr, port_addr} : 32'hDEAD_BEEF;

    isa_io_bridge u_isa_io_bridge (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .map_discontig(map_discontig), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .port_req(port_req), .port_we(port_we),
        .port_addr(port_addr), .port_size(port_size),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .irq_vec(irq_vec), .iack_strobe(iack_strobe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'd0) return {24'h0, d[7:0]};
        if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [15:0] exp_port(input logic [22:0] off, input logic disc);
        if (disc) return 16'((off & 23'h1F) | ((off & 23'h7FF000) >> 7));
        return off[15:0];
    endfunction

    // One access: request, check stage 1, check completion.
    task automatic access(input logic [31:0] addr, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, input logic disc);
        logic in_win;
        logic in_ack;
        logic vec_rd;
        logic [15:0] ep;
        logic [31:0] er;
        in_win = (addr >= 32'h8000_0000) && (addr < 32'h8080_0000);
        in_ack = (addr[31:2] == 30'h2FFF_FFFC);
        vec_rd = in_ack && !we && (addr[1:0] == 2'b00);
        ep = exp_port(addr[22:0], disc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_size = sz;
        cpu_wdata = wd; map_discontig = disc;
        @(negedge clk);
        cpu_req = 1'b0;
        map_discontig = ~disc; // R4: flip after issue
        chk("R1 port_req", 32'(port_req), 32'(in_win));
        chk("R12 done early", 32'(cpu_done), 32'h0);
        chk("R7/R8/R9 iack_strobe", 32'(iack_strobe), 32'(vec_rd));
        if (in_win) begin
            chk(disc ? "R3/R4 port_addr" : "R2/R4 port_addr", 32'(port_addr), 32'(ep));
            chk("R1 port_we", 32'(port_we), 32'(we));
            chk("R1 port_size", 32'(port_size), 32'(sz));
            chk("R5 port_wdata", port_wdata, we ? lanes(wd, sz) : 32'h0);
        end
        er = 32'h0;
        if (in_win && !we) er = lanes({~ep, ep}, sz);
        if (vec_rd) er = lanes({24'h0, irq_vec}, sz);
        @(negedge clk);
        chk("R12 cpu_done", 32'(cpu_done), 32'h1);
        chk(in_win ? "R6 cpu_rdata" : "R7/R8/R9/R10 cpu_rdata", cpu_rdata, er);
        chk("R1/R10 port idle", 32'(port_req), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 port_req", 32'(port_req), 0);
        chk("R11 iack", 32'(iack_strobe), 0);
        chk("R11 done", 32'(cpu_done), 0);
        chk("R11 rdata", cpu_rdata, 0);
        chk("R11 port_addr", 32'(port_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after release", 32'(cpu_done | port_req | iack_strobe), 0);

        // Single-bit offset sweep in both mappings, all sizes and directions.
        for (int m = 0; m < 2; m++)
            for (int sz = 0; sz < 4; sz++)
                for (int w = 0; w < 2; w++)
                    for (int b = 0; b < 23; b++)
                        access(32'h8000_0000 | (32'h1 << b), w[0], sz[1:0],
                               32'h1122_3344 + 32'(b), m[0]);
        // Dense offsets and window edges
        for (int m = 0; m < 2; m++) begin
            access(32'h8000_0000, 1'b0, 2'd2, 0, m[0]);
            access(32'h807F_FFFF, 1'b0, 2'd1, 0, m[0]);
            access(32'h807F_FFFF, 1'b1, 2'd2, 32'hA1B2_C3D4, m[0]);
            access(32'h8055_AA5F, 1'b0, 2'd2, 0, m[0]);
            access(32'h802A_5FE3, 1'b1, 2'd1, 32'h0000_BEEF, m[0]);
        end
        // R10 just outside the window and elsewhere
        access(32'h8080_0000, 1'b0, 2'd2, 0, 1'b0);
        access(32'h7FFF_FFFF, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
        access(32'hBFFF_FFEF, 1'b0, 2'd0, 0, 1'b1);
        access(32'hBFFF_FFF4, 1'b0, 2'd0, 0, 1'b0);
        // R7 vector reads at every size, two vectors
        for (int v = 0; v < 2; v++) begin
            irq_vec = v[0] ? 8'hC3 : 8'h5A;
            for (int sz = 0; sz < 3; sz++) access(32'hBFFF_FFF0, 1'b0, sz[1:0], 0, 1'b0);
        end
        // R8 misaligned acknowledge reads; R9 acknowledge writes
        for (int o = 1; o < 4; o++) access(32'hBFFF_FFF0 + 32'(o), 1'b0, 2'd0, 0, 1'b0);
        for (int o = 0; o < 4; o++) access(32'hBFFF_FFF0 + 32'(o), 1'b1, 2'd2, 32'h1234_5678, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule